// File: doc/BRIEF.md
# Rotating Triple-Bank Activation Store

This block keeps neuron activation values for a mean-field annealing engine in three equal banks. At any moment each bank has one of three roles. The *next* bank is filled by the host. The *current* bank is read and rewritten by the anneal datapath. The *last* bank holds a finished pattern, which the weight-update logic reads. All three ports can work in the same cycle because each one always addresses a different bank.

Each bank has two halves. Half 0 holds the teacher activations and half 1 holds the student activations. Each half has one entry per neuron. A single rotate command moves every role one step: the next bank becomes current, the current bank becomes last, and the last bank becomes next. The rotation only changes a 2-bit pointer, so no data is copied.

The anneal port selects a half through its phase input. Writes from that port are filtered by two per-neuron masks, an input mask and an output mask. In the teacher phase, neurons in either mask are held. In the student phase, only neurons in the input mask are held. For recall, a pattern is loaded into the student half, annealed in the student phase, and read back from the student half at the update port.

Top module: `rot_act_store`

## Requirements
- R1: After reset the current-bank index is 0, the rotate acknowledge is low, and all read-data outputs are zero. With current index c, the next bank is (c+1) mod 3 and the last bank is (c+2) mod 3.
- R2: A rotate request is accepted only in a cycle where the load, anneal and update enables are all low. On acceptance, the acknowledge is high in the following cycle and the current index advances by one modulo 3 (2 wraps to 0). If any enable is high, the request is ignored and the index holds.
- R3: Data written at the load port goes to the next bank. After one accepted rotate it is readable at the anneal port. After a second accepted rotate it is readable at the update port.
- R4: Teacher (half 0) and student (half 1) entries at the same neuron address are stored separately. Writing one half does not change the other.
- R5: In the teacher phase (phase=0), an anneal write to a neuron whose input-mask or output-mask bit is set is dropped, and the stored value is unchanged.
- R6: In the student phase (phase=1), an anneal write is dropped only when the neuron's input-mask bit is set. A set output-mask bit does not block it.
- R7: An update-port read returns the teacher and student values of the addressed neuron together, in the cycle after the request.
- R8: A load, an anneal write and an update read issued in the same cycle each act on their own role's bank, and none disturbs the others.
- R9: An address at or above the neuron count is out of range. A write to it is dropped, and a read of it returns zero.
- R10: Anneal read data appears in the cycle after a read request (enable high, write low). In a cycle without such a request it is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rot_req | input | 1 | Request to rotate bank roles |
| rot_ack | output | 1 | High for a cycle after an accepted rotate |
| cur_bank | output | 2 | Index of the bank in the current role |
| ld_en | input | 1 | Load-port write enable |
| ld_half | input | 1 | Load half: 0 teacher, 1 student |
| ld_addr | input | AW | Load neuron address |
| ld_data | input | DW | Load data |
| an_en | input | 1 | Anneal-port access enable |
| an_we | input | 1 | Anneal access is a write |
| an_phase | input | 1 | Anneal phase/half: 0 teacher, 1 student |
| an_addr | input | AW | Anneal neuron address |
| an_wdata | input | DW | Anneal write data |
| an_rdata | output | DW | Anneal read data, one cycle latency |
| clamp_in | input | N | Input-neuron clamp mask |
| clamp_out | input | N | Output-neuron clamp mask |
| up_en | input | 1 | Update-port read enable |
| up_addr | input | AW | Update neuron address |
| up_teach | output | DW | Teacher value from the last bank |
| up_stud | output | DW | Student value from the last bank |

## Verification
The assertions check the rotation rules on every cycle:
- an acknowledge only follows an idle request;
- every idle request is acknowledged;
- the index advances by exactly one step modulo 3, never takes the value 3, and holds when no rotate occurs;
- out-of-range update reads and cycles without an anneal read give zero data.

Only the bench scenarios can show that data follows its bank through the roles across two rotations. The same holds for keeping the two halves apart, the phase-dependent clamp filtering, and three ports acting in one cycle without interference.

// File: rtl/rot_act_store.sv
module rot_act_store #(
  parameter int N  = 160,
  parameter int DW = 5,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rot_req,
  output logic          rot_ack,
  output logic [1:0]    cur_bank,
  input  logic          ld_en,
  input  logic          ld_half,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic          an_en,
  input  logic          an_we,
  input  logic          an_phase,
  input  logic [AW-1:0] an_addr,
  input  logic [DW-1:0] an_wdata,
  output logic [DW-1:0] an_rdata,
  input  logic [N-1:0]  clamp_in,
  input  logic [N-1:0]  clamp_out,
  input  logic          up_en,
  input  logic [AW-1:0] up_addr,
  output logic [DW-1:0] up_teach,
  output logic [DW-1:0] up_stud
);

  logic [1:0]    ptr;
  logic [1:0]    nxt_b, lst_b;
  logic          idle, ld_ok, an_ok, up_ok, held;
  logic [N-1:0]  teach_hold;
  logic [DW-1:0] mem [3][2][N];

  assign nxt_b = (ptr == 2'd2) ? 2'd0 : ptr + 2'd1;
  assign lst_b = (ptr == 2'd0) ? 2'd2 : ptr - 2'd1;
  assign idle  = !(ld_en || an_en || up_en);
  assign ld_ok = 32'(ld_addr) < N;
  assign an_ok = 32'(an_addr) < N;
  assign up_ok = 32'(up_addr) < N;
  assign teach_hold = clamp_in | clamp_out;
  assign held  = an_ok && (an_phase ? clamp_in[an_addr] : teach_hold[an_addr]);
  assign cur_bank = ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr     <= 2'd0;
      rot_ack <= 1'b0;
    end else begin
      rot_ack <= rot_req && idle;
      if (rot_req && idle) ptr <= nxt_b;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_en && ld_ok)
      mem[nxt_b][ld_half][ld_addr] <= ld_data;
    if (an_en && an_we && an_ok && !held)
      mem[ptr][an_phase][an_addr] <= an_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      an_rdata <= '0;
      up_teach <= '0;
      up_stud  <= '0;
    end else begin
      an_rdata <= (an_en && !an_we && an_ok) ? mem[ptr][an_phase][an_addr] : '0;
      up_teach <= (up_en && up_ok) ? mem[lst_b][0][up_addr] : '0;
      up_stud  <= (up_en && up_ok) ? mem[lst_b][1][up_addr] : '0;
    end
  end

  a_r2_ack_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    rot_ack |-> $past(rot_req && !ld_en && !an_en && !up_en));

  a_r2_idle_req_acked: assert property (@(posedge clk) disable iff (!rst_n)
    (rot_req && !ld_en && !an_en && !up_en) |=> rot_ack);

  a_r2_index_advance: assert property (@(posedge clk) disable iff (!rst_n)
    rot_ack |-> cur_bank == (($past(cur_bank) == 2'd2) ? 2'd0 : $past(cur_bank) + 2'd1));

  a_r2_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rot_ack |-> $stable(cur_bank));

  a_r1_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    cur_bank != 2'd3);

  a_r9_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (up_en && 32'(up_addr) >= N) |=> (up_teach == '0 && up_stud == '0));

  a_r10_no_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !(an_en && !an_we) |=> an_rdata == '0);

endmodule

// File: tb/sim_rot_act_store.sv
`timescale 1ns/1ps
module sim_rot_act_store;
  localparam int N = 160;
  localparam int DW = 5;
  localparam int AW = $clog2(N);

  logic clk = 0, rst_n = 0;
  logic rot_req = 0, rot_ack;
  logic [1:0] cur_bank;
  logic ld_en = 0, ld_half = 0;
  logic [AW-1:0] ld_addr = '0;
  logic [DW-1:0] ld_data = '0;
  logic an_en = 0, an_we = 0, an_phase = 0;
  logic [AW-1:0] an_addr = '0;
  logic [DW-1:0] an_wdata = '0, an_rdata;
  logic [N-1:0] clamp_in = '0, clamp_out = '0;
  logic up_en = 0;
  logic [AW-1:0] up_addr = '0;
  logic [DW-1:0] up_teach, up_stud;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rot_act_store #(.N(N), .DW(DW)) u0 (.*);

  // {addr, teacher, student}
  localparam logic [17:0] VEC [8] = '{
    {8'd0,   5'd3,  5'd28}, {8'd1,   5'd17, 5'd2},
    {8'd37,  5'd31, 5'd0},  {8'd80,  5'd9,  5'd22},
    {8'd99,  5'd14, 5'd15}, {8'd120, 5'd1,  5'd30},
    {8'd158, 5'd26, 5'd11}, {8'd159, 5'd6,  5'd19}};

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic load(bit h, int a, int d);
    @(negedge clk); ld_en = 1; ld_half = h; ld_addr = AW'(a); ld_data = DW'(d);
    @(negedge clk); ld_en = 0;
  endtask

  task automatic an_wr(bit ph, int a, int d);
    @(negedge clk); an_en = 1; an_we = 1; an_phase = ph; an_addr = AW'(a); an_wdata = DW'(d);
    @(negedge clk); an_en = 0; an_we = 0;
  endtask

  task automatic an_rd(bit ph, int a, output logic [DW-1:0] v);
    @(negedge clk); an_en = 1; an_we = 0; an_phase = ph; an_addr = AW'(a);
    @(negedge clk); v = an_rdata; an_en = 0;
  endtask

  task automatic up_rd(int a, output logic [DW-1:0] t, output logic [DW-1:0] s);
    @(negedge clk); up_en = 1; up_addr = AW'(a);
    @(negedge clk); t = up_teach; s = up_stud; up_en = 0;
  endtask

  task automatic rotate(int exp_bank);
    @(negedge clk); rot_req = 1;
    @(negedge clk); rot_req = 0;
    chk("R2 ack", 8'(rot_ack), 8'd1);
    chk("R2 index", 8'(cur_bank), 8'(exp_bank));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] v, t, s;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 index", 8'(cur_bank), 8'd0);
    chk("R1 ack", 8'(rot_ack), 8'd0);
    chk("R1 an_rdata", 8'(an_rdata), 8'd0);
    chk("R1 up_teach", 8'(up_teach), 8'd0);
    chk("R1 up_stud", 8'(up_stud), 8'd0);

    // R3/R4: table into next bank (bank 1)
    foreach (VEC[i]) begin
      load(0, int'(VEC[i][17:10]), int'(VEC[i][9:5]));
      load(1, int'(VEC[i][17:10]), int'(VEC[i][4:0]));
    end
    rotate(1);
    foreach (VEC[i]) begin
      an_rd(0, int'(VEC[i][17:10]), v); chk("R3 R4 anneal teacher", 8'(v), 8'(VEC[i][9:5]));
      an_rd(1, int'(VEC[i][17:10]), v); chk("R3 R4 anneal student", 8'(v), 8'(VEC[i][4:0]));
    end
    rotate(2);
    foreach (VEC[i]) begin
      up_rd(int'(VEC[i][17:10]), t, s);
      chk("R3 R7 update teacher", 8'(t), 8'(VEC[i][9:5]));
      chk("R3 R7 update student", 8'(s), 8'(VEC[i][4:0]));
    end

    // R2: rotate while a port is busy is ignored
    @(negedge clk); rot_req = 1; up_en = 1; up_addr = 8'd0;
    @(negedge clk); rot_req = 0; up_en = 0;
    chk("R2 busy no ack", 8'(rot_ack), 8'd0);
    chk("R2 busy index hold", 8'(cur_bank), 8'd2);

    // R5/R6: clamp filtering in current bank 2
    an_wr(0, 5, 3);  an_wr(1, 5, 4);  an_wr(0, 6, 10); an_wr(1, 6, 11);
    clamp_in[5] = 1; clamp_out[6] = 1;
    an_wr(0, 5, 7);  an_rd(0, 5, v); chk("R5 teacher input-clamped", 8'(v), 8'd3);
    an_wr(0, 6, 20); an_rd(0, 6, v); chk("R5 teacher output-clamped", 8'(v), 8'd10);
    an_wr(1, 6, 21); an_rd(1, 6, v); chk("R6 student output free", 8'(v), 8'd21);
    an_wr(1, 5, 22); an_rd(1, 5, v); chk("R6 student input-clamped", 8'(v), 8'd4);
    clamp_in = '0; clamp_out = '0;

    // R8: three ports in one cycle
    @(negedge clk);
    ld_en = 1; ld_half = 0; ld_addr = 8'd10; ld_data = 5'd9;
    an_en = 1; an_we = 1; an_phase = 0; an_addr = 8'd10; an_wdata = 5'd21;
    up_en = 1; up_addr = 8'd37;
    @(negedge clk);
    ld_en = 0; an_en = 0; an_we = 0; up_en = 0;
    chk("R8 update during traffic", 8'(up_teach), 8'd31);
    an_rd(0, 10, v); chk("R8 anneal write kept", 8'(v), 8'd21);
    rotate(0);
    an_rd(0, 10, v); chk("R8 load landed in next", 8'(v), 8'd9);
    up_rd(10, t, s); chk("R8 anneal data now last", 8'(t), 8'd21);

    // R9: out-of-range
    up_rd(200, t, s);
    chk("R9 oob update teacher", 8'(t), 8'd0);
    chk("R9 oob update student", 8'(s), 8'd0);
    an_wr(0, 160, 13); an_rd(0, 160, v); chk("R9 oob anneal", 8'(v), 8'd0);

    // R10: no read request gives zero
    @(negedge clk); chk("R10 idle rdata", 8'(an_rdata), 8'd0);

    // R2: full wrap
    rotate(1); rotate(2); rotate(0);
    finish_run();
  end
endmodule